// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block behaves like a small fuse-programmed logic device. Eight dedicated inputs and four pins feed a programmable AND plane. Each signal reaches the plane twice, once as it is and once inverted. Each of the four outputs ORs its own fixed group of four product terms. An XOR stage, set by a polarity bit, can then invert the result. A fifth product term per output decides whether the pin driver is enabled. The resolved value on each pin comes back into the array as a signal, so a pin that is not driven acts as an extra input.

The configuration is a single vector of 484 bits. It is shifted in serially, most significant bit first, into a staging register. The programmed logic stays unchanged until a commit command copies the staging register into the active map. A read command loads the active map into the same register so that it can be shifted out. A security command hides the map from readback, and the logic keeps working as before. Only an erase command clears the security bit, and it also restores every connection to intact. A five-state controller carries out these commands. The evaluation path from the inputs to the pins has no register in it.

Controller states: `ST_IDLE` accepts commands and performs shifts. `ST_COMMIT`, `ST_READ`, `ST_SECURE` and `ST_ERASE` each carry out their action in one cycle. Transitions: from `ST_IDLE` to the state named by a non-zero command, and from every action state back to `ST_IDLE` after one cycle.

Top module: `pal_array`

## Requirements
- R1: After reset every output enable is 0, every pin value is 0, the serial output is 0 and the active map is fully intact (all ones, security clear).
- R2: Map layout: the term for output o, slot t (0 to 3 for the sum terms, 4 for the enable term) sits at bits [(o*5+t)*24 +: 24]. Within a term, bit 2k is the true line and bit 2k+1 the inverted line of signal k, where signals 0 to 7 are `in_i` and signals 8 to 11 are `pin_fb_i`. A bit value of 1 means connected. A term is true when every connected line is 1. `pin_o[o]` is the OR of its four sum terms, then passed through the polarity stage.
- R3: A term with all 24 bits at 1 evaluates to 0. A device whose terms are all intact therefore drives no pin and outputs 0.
- R4: A term with all bits at 0 (every line disconnected) evaluates to 1.
- R5: The polarity bit for output o is map bit 480+o. A value of 1 passes the sum through unchanged. A value of 0 inverts it.
- R6: `pin_oe[o]` equals the enable term of output o. The pin values on `pin_fb_i` feed the array as signals 8 to 11.
- R7: While the controller is in `ST_IDLE`, `cfg_shift_i` moves `cfg_sdi_i` into the staging register LSB-first at the tail, so the first bit shifted in ends up at the MSB. Shifting has no effect on the logic until command 1 (commit) is given. The commit takes effect on the second rising edge after the command is presented.
- R8: Command 2 (read) loads the active map into the staging register. `cfg_sdo_o` then shows map bit 483, and each shift presents the next lower bit.
- R9: Command 3 (secure) sets the security bit. After it, a read loads all zeros, while the logic outputs are unchanged.
- R10: Command 4 (erase) sets every map bit to 1 and clears the security bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_i | input | 8 | Dedicated logic inputs |
| pin_fb_i | input | 4 | Resolved pin values fed back to the array |
| cfg_shift_i | input | 1 | Shift the staging register by one bit |
| cfg_sdi_i | input | 1 | Serial configuration data in |
| cfg_cmd_i | input | 3 | Command: 0 none, 1 commit, 2 read, 3 secure, 4 erase |
| cfg_sdo_o | output | 1 | Serial data out (MSB of the staging register) |
| pin_o | output | 4 | Output values after the polarity stage |
| pin_oe | output | 4 | Output driver enables |

## Verification
The array is exercised with directed maps that separate the cases. These are a single two-literal term, a fully disconnected term, a fully intact term, an inverted-polarity output and a term driven by a fed-back pin. Each case shows whether the AND plane and the polarity stage follow the bit layout. Several random maps are built from sparse terms, with a random literal polarity on each term, and are driven with random input and feedback patterns. These catch any index swap between signals, true and inverted lines, or term slots. Shifting without a commit, reading before and after securing, and erasing tell apart staging from the active map, the hidden map from the working logic, and the erase from a plain reset.

// File: rtl/pal_pkg.sv
package pal_pkg;
    typedef enum logic [2:0] {
        CMD_NOP    = 3'd0,
        CMD_COMMIT = 3'd1,
        CMD_READ   = 3'd2,
        CMD_SECURE = 3'd3,
        CMD_ERASE  = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COMMIT,
        ST_READ,
        ST_SECURE,
        ST_ERASE
    } state_e;
endpackage

// File: rtl/pal_term.sv
module pal_term #(
    parameter int unsigned LW = 24
) (
    input  logic [LW-1:0] fuse_i,
    input  logic [LW-1:0] line_i,
    output logic          hit_o
);
    // A disconnected line (fuse 0) never pulls the product low.
    assign hit_o = &(line_i | ~fuse_i);

    // An intact term holds a signal and its inverse at once.
    always_comb begin
        if (&fuse_i) AST_TERM_INTACT_ZERO: assert (hit_o == 1'b0); // R3
    end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell #(
    parameter int unsigned N_SUM = 4,
    parameter int unsigned LW    = 24,
    localparam int unsigned TPO  = N_SUM + 1
) (
    input  logic [TPO*LW-1:0] fuse_i,
    input  logic              pol_i,
    input  logic [LW-1:0]     line_i,
    output logic              out_o,
    output logic              oe_o
);
    logic [TPO-1:0] hit;

    for (genvar t = 0; t < TPO; t++) begin : g_term
        pal_term #(.LW(LW)) u_term (
            .fuse_i (fuse_i[t*LW +: LW]),
            .line_i (line_i),
            .hit_o  (hit[t])
        );
    end

    logic sum;
    assign sum   = |hit[N_SUM-1:0];
    // Intact polarity bit holds the XOR input at 0.
    assign out_o = sum ^ ~pol_i;
    assign oe_o  = hit[N_SUM];
endmodule

// File: rtl/pal_cfg_ctrl.sv
module pal_cfg_ctrl
    import pal_pkg::*;
#(
    parameter int unsigned MAP_W = 484
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic             sdi_i,
    input  logic [2:0]       cmd_i,
    output logic [MAP_W-1:0] map_o,
    output logic             sdo_o
);
    state_e           state_q, state_d;
    logic [MAP_W-1:0] map_q, stage_q;
    logic             secure_q;

    always_comb begin
        state_d = ST_IDLE;
        if (state_q == ST_IDLE) begin
            unique case (cmd_e'(cmd_i))
                CMD_COMMIT: state_d = ST_COMMIT;
                CMD_READ:   state_d = ST_READ;
                CMD_SECURE: state_d = ST_SECURE;
                CMD_ERASE:  state_d = ST_ERASE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q    <= '1;
            stage_q  <= '0;
            secure_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (shift_i) stage_q <= {stage_q[MAP_W-2:0], sdi_i};
                end
                ST_COMMIT: map_q <= stage_q;
                ST_READ:   stage_q <= secure_q ? '0 : map_q;
                ST_SECURE: secure_q <= 1'b1;
                ST_ERASE: begin
                    map_q    <= '1;
                    secure_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign map_o = map_q;
    assign sdo_o = stage_q[MAP_W-1];

    AST_MAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_COMMIT && state_q != ST_ERASE) |=> $stable(map_q)); // R7

    AST_SECURE_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && secure_q) |=> (stage_q == '0)); // R9

    AST_ERASE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE) |=> (!secure_q && (&map_q))); // R10

    AST_ACTION_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q == ST_IDLE)); // R7
endmodule

// File: rtl/pal_array.sv
module pal_array #(
    parameter int unsigned N_IN  = 8,
    parameter int unsigned N_OUT = 4,
    parameter int unsigned N_SUM = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  in_i,
    input  logic [N_OUT-1:0] pin_fb_i,
    input  logic             cfg_shift_i,
    input  logic             cfg_sdi_i,
    input  logic [2:0]       cfg_cmd_i,
    output logic             cfg_sdo_o,
    output logic [N_OUT-1:0] pin_o,
    output logic [N_OUT-1:0] pin_oe
);
    localparam int unsigned N_SIG  = N_IN + N_OUT;
    localparam int unsigned LW     = 2 * N_SIG;
    localparam int unsigned TPO    = N_SUM + 1;
    localparam int unsigned TERM_W = N_OUT * TPO * LW;
    localparam int unsigned MAP_W  = TERM_W + N_OUT;

    logic [MAP_W-1:0] cfg_map;
    logic [N_SIG-1:0] sig;
    logic [LW-1:0]    lines;

    pal_cfg_ctrl #(.MAP_W(MAP_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (cfg_shift_i),
        .sdi_i   (cfg_sdi_i),
        .cmd_i   (cfg_cmd_i),
        .map_o   (cfg_map),
        .sdo_o   (cfg_sdo_o)
    );

    assign sig = {pin_fb_i, in_i};

    for (genvar k = 0; k < N_SIG; k++) begin : g_line
        assign lines[2*k]   = sig[k];
        assign lines[2*k+1] = ~sig[k];
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_cell
        pal_macrocell #(.N_SUM(N_SUM), .LW(LW)) u_cell (
            .fuse_i (cfg_map[o*TPO*LW +: TPO*LW]),
            .pol_i  (cfg_map[TERM_W + o]),
            .line_i (lines),
            .out_o  (pin_o[o]),
            .oe_o   (pin_oe[o])
        );
    end

    AST_ERASED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&cfg_map) |-> (pin_oe == '0 && pin_o == '0)); // R3

    AST_RESET_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0)); // R1
endmodule

// File: tb/sim_pal_array.sv
module sim_pal_array;
    localparam int MW = 484;
    localparam int LW = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_i = '0;
    logic [3:0] pin_fb_i = '0;
    logic       cfg_shift_i = 1'b0;
    logic       cfg_sdi_i = 1'b0;
    logic [2:0] cfg_cmd_i = '0;
    logic       cfg_sdo_o;
    logic [3:0] pin_o, pin_oe;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pal_array u0 (
        .clk(clk), .rst_n(rst_n), .in_i(in_i), .pin_fb_i(pin_fb_i),
        .cfg_shift_i(cfg_shift_i), .cfg_sdi_i(cfg_sdi_i), .cfg_cmd_i(cfg_cmd_i),
        .cfg_sdo_o(cfg_sdo_o), .pin_o(pin_o), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [MW-1:0] act, input logic [MW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [MW-1:0] m, input logic [7:0] a, input logic [3:0] fb);
        logic [11:0] s;
        logic [3:0]  o_v, e_v;
        s = {fb, a};
        for (int o = 0; o < 4; o++) begin
            logic sum;
            sum = 1'b0;
            for (int t = 0; t < 5; t++) begin
                logic hit;
                hit = 1'b1;
                for (int l = 0; l < LW; l++) begin
                    logic v;
                    v = (l % 2 == 1) ? ~s[l/2] : s[l/2];
                    if (m[(o*5+t)*LW + l] && !v) hit = 1'b0;
                end
                if (t < 4) sum = sum | hit;
                else       e_v[o] = hit;
            end
            o_v[o] = sum ^ ~m[480+o];
        end
        return {e_v, o_v};
    endfunction

    function automatic logic [LW-1:0] rand_term();
        logic [LW-1:0] f;
        f = '0;
        for (int k = 0; k < 12; k++)
            if ($urandom_range(3) == 0) f[2*k + ($urandom_range(1))] = 1'b1;
        return f;
    endfunction

    function automatic logic [MW-1:0] rand_map();
        logic [MW-1:0] m;
        m = '1;
        for (int i = 0; i < 20; i++) begin
            int r;
            r = $urandom_range(5);
            if (r == 0)      m[i*LW +: LW] = '1;
            else if (r == 1) m[i*LW +: LW] = '0;
            else             m[i*LW +: LW] = rand_term();
        end
        m[483:480] = 4'($urandom);
        return m;
    endfunction

    task automatic shift_in(input logic [MW-1:0] m);
        for (int i = MW-1; i >= 0; i--) begin
            @(negedge clk);
            cfg_shift_i = 1'b1;
            cfg_sdi_i   = m[i];
        end
        @(negedge clk);
        cfg_shift_i = 1'b0;
        cfg_sdi_i   = 1'b0;
    endtask

    task automatic do_cmd(input logic [2:0] c);
        @(negedge clk);
        cfg_cmd_i = c;
        @(negedge clk);
        cfg_cmd_i = 3'd0;
        @(negedge clk);
    endtask

    task automatic read_out(output logic [MW-1:0] got);
        for (int i = MW-1; i >= 0; i--) begin
            got[i] = cfg_sdo_o;
            cfg_shift_i = 1'b1;
            @(negedge clk);
        end
        cfg_shift_i = 1'b0;
    endtask

    task automatic apply_chk(input string req, input logic [MW-1:0] m,
                             input logic [7:0] a, input logic [3:0] fb);
        in_i = a;
        pin_fb_i = fb;
        #1;
        chk(req, MW'({pin_oe, pin_o}), MW'(model(m, a, fb)));
    endtask

    initial begin
        logic [MW-1:0] dmap, m2, got;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet reset state
        chk("R1 oe", MW'(pin_oe), '0);
        chk("R1 out", MW'(pin_o), '0);
        chk("R1 sdo", MW'(cfg_sdo_o), '0);

        // R3: erased device never drives, for any inputs
        for (int i = 0; i < 8; i++) begin
            in_i = 8'($urandom); pin_fb_i = 4'($urandom); #1;
            chk("R3 erased", MW'({pin_oe, pin_o}), '0);
        end

        // Directed map
        dmap = '1;
        dmap[(0*5+0)*LW +: LW] = 24'h000009;  // in0 & ~in1
        dmap[(0*5+4)*LW +: LW] = 24'h000000;  // oe0 always on
        dmap[(1*5+0)*LW +: LW] = 24'h000000;  // R4: always-true term
        dmap[482]              = 1'b0;        // R5: invert output 2
        dmap[(3*5+0)*LW +: LW] = 24'h010000;  // pin 0 feedback
        dmap[(3*5+4)*LW +: LW] = 24'h000000;
        shift_in(dmap);
        #1;
        chk("R7 no commit yet", MW'({pin_oe, pin_o}), MW'(model('1, in_i, pin_fb_i)));
        do_cmd(3'd1);

        in_i = 8'b0000_0001; pin_fb_i = 4'b0000; #1;
        chk("R2 in0&~in1 true", MW'(pin_o[0]), MW'(1'b1));
        chk("R4 blown term", MW'(pin_o[1]), MW'(1'b1));
        chk("R5 inverted", MW'(pin_o[2]), MW'(1'b1));
        chk("R6 oe", MW'(pin_oe), MW'(4'b1001));
        in_i = 8'b0000_0011; #1;
        chk("R2 in0&~in1 false", MW'(pin_o[0]), MW'(1'b0));
        pin_fb_i = 4'b0001; #1;
        chk("R6 feedback high", MW'(pin_o[3]), MW'(1'b1));
        pin_fb_i = 4'b1110; #1;
        chk("R6 feedback low", MW'(pin_o[3]), MW'(1'b0));

        // R8: readback of the committed map
        do_cmd(3'd2);
        chk("R8 first bit", MW'(cfg_sdo_o), MW'(dmap[483]));
        read_out(got);
        chk("R8 readback", got, dmap);

        // R7: staging a new map leaves the logic alone
        m2 = rand_map();
        shift_in(m2);
        for (int i = 0; i < 4; i++)
            apply_chk("R7 staged only", dmap, 8'($urandom), 4'($urandom));

        // R2: random maps and random vectors
        for (int n = 0; n < 6; n++) begin
            if (n > 0) begin
                m2 = rand_map();
                shift_in(m2);
            end
            do_cmd(3'd1);
            for (int v = 0; v < 30; v++)
                apply_chk("R2 random", m2, 8'($urandom), 4'($urandom));
        end

        // R9: secure hides the map, logic unchanged
        do_cmd(3'd3);
        for (int i = 0; i < 4; i++)
            apply_chk("R9 logic kept", m2, 8'($urandom), 4'($urandom));
        do_cmd(3'd2);
        read_out(got);
        chk("R9 readback zero", got, '0);

        // R10: erase restores intact map and clears security
        do_cmd(3'd4);
        apply_chk("R10 erased logic", '1, 8'hA5, 4'h3);
        chk("R10 oe off", MW'(pin_oe), '0);
        do_cmd(3'd2);
        read_out(got);
        chk("R10 readback ones", got, '1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule